// File: doc/BRIEF.md
# Port-Routed Frame Dispatcher

The dispatcher sits between a word-wide receive stream and a small set of client ports, and also merges those clients' outgoing traffic onto one shared transmit stream. On the receive side each frame arrives as 32-bit words. The first word is the number of payload words. Words are then skipped until one carries the 16-bit protocol tag 0x45C0 in its upper half. The low byte of that word names the destination port. A port outside the configured range makes the dispatcher pulse a discard strobe so that the source drops the rest of the frame. A valid port gets its ready flag raised, and that client then pulls payload words through a blocking request/acknowledge read until the length count runs out. This lowers the flag and frees the dispatcher for the next frame.

On the transmit side each client offers a word stream tagged start, middle or end. A round-robin arbiter grants one client that is offering a start-tagged word and holds the grant through its end-tagged word. The dispatcher first emits a header word carrying the protocol tag, a fixed flag byte 0x32 and the sender's port number, then a frame sequence number. The client's words follow: the start word holds the payload length, and the words after it are the payload.

The receive machine has four states. RX_LEN accepts the length word and goes to RX_SCAN. RX_SCAN stays put on a non-matching word. On a matching word it goes to RX_DROP for a bad port, back to RX_LEN for a zero length, and to RX_HOLD otherwise. RX_HOLD returns to RX_LEN on the last payload read. RX_DROP always returns to RX_LEN after one cycle. The transmit machine has five states. TX_IDLE goes to TX_HEAD once any start word is offered. TX_HEAD goes to TX_SEQ, and TX_SEQ goes to TX_LEN, each on output ready. TX_LEN goes to TX_BODY when the length word is handed over. TX_BODY returns to TX_IDLE when the end word is handed over.

Top module: `frame_dispatch`

## Requirements
- R1: After reset no port ready flag is set, the transmit output is not valid and no read acknowledge is given.
- R2: The first accepted word of a frame is its payload length. After it, every word whose bits 31:16 differ from 0x45C0 is accepted and skipped.
- R3: On a header word (bits 31:16 = 0x45C0) whose bits 7:0 name a port below NPORTS and with nonzero length, exactly that port's ready flag is set from the next cycle on.
- R4: On a header word whose bits 7:0 are NPORTS or above, the discard strobe is high for exactly one cycle, starting the cycle after. No flag is raised and the receive input is not ready during that cycle. The next word accepted is a new length word.
- R5: While a port's flag is set, the receive ready follows that port's read request. The port's acknowledge is high in the same cycle as request and receive valid are both high, and the read data equals the receive word.
- R6: The flag clears in the cycle after the read whose count equals the frame length, and the dispatcher then accepts a new length word.
- R7: A read request on a port whose flag is clear gets no acknowledge and consumes nothing.
- R8: A header with length zero raises no flag and returns to accepting a length word.
- R9: Among clients offering a start-tagged word (tag 2'b01), the grant goes to the first one after the last granted port in rising circular order. After reset the search starts at port 0.
- R10: A granted frame appears on the output as the header word {0x45C0, 0x32, port}, the sequence word, the client's start word, and its payload through the end-tagged word (tag 2'b10; middle is 2'b00), with no other client's word in between.
- R11: The sequence word is 0 for the first frame after reset and increments by one per completed frame.
- R12: While the output is valid and not ready, it stays valid with unchanged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_vld | input | 1 | Receive word valid |
| rx_data | input | DW | Receive word |
| rx_rdy | output | 1 | Receive word accepted when high with rx_vld |
| rx_drop | output | 1 | Discard remainder of current frame |
| rd_req | input | NPORTS | Per-port read request |
| rd_ack | output | NPORTS | Per-port read acknowledge |
| rd_data | output | DW | Read data, valid with an acknowledge |
| port_ready | output | NPORTS | Per-port frame-ready flags |
| tx_vld | input | NPORTS | Per-client transmit word valid |
| tx_tag | input | 2*NPORTS | Per-client word tag: start 01, middle 00, end 10 |
| tx_data | input | DW*NPORTS | Per-client transmit word |
| tx_ack | output | NPORTS | Per-client word taken |
| out_vld | output | 1 | Shared transmit word valid |
| out_data | output | DW | Shared transmit word |
| out_rdy | input | 1 | Downstream ready |

## Verification
Payload delivery to a client and transmit beats share no state, so they can fall in the same cycle. The bench runs a full sweep of receive frames over every valid and invalid port, while all four clients contend for transmit and the output ready stalls one cycle in three. Every received word and every emitted word is compared against values the bench computes from the frame contents and the predicted round-robin order. A neighbouring port's read request is raised together with every payload read, so a delivery and a refused read also coincide and are judged in that same cycle.

// File: rtl/fd_pkg.sv
package fd_pkg;

    typedef enum logic [1:0] {
        TAG_MID   = 2'b00,
        TAG_START = 2'b01,
        TAG_END   = 2'b10
    } fd_tag_e;

    typedef enum logic [1:0] {
        RX_LEN,
        RX_SCAN,
        RX_HOLD,
        RX_DROP
    } rx_state_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_HEAD,
        TX_SEQ,
        TX_LEN,
        TX_BODY
    } tx_state_e;

    localparam logic [15:0] PROTO_TAG = 16'h45C0;
    localparam logic [7:0]  HDR_FLAGS = 8'h32;

endpackage

// File: rtl/fd_rx_demux.sv
module fd_rx_demux
    import fd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_vld,
    input  logic [DW-1:0]     rx_data,
    output logic              rx_rdy,
    output logic              rx_drop,
    input  logic [NPORTS-1:0] rd_req,
    output logic [NPORTS-1:0] rd_ack,
    output logic [NPORTS-1:0] port_ready
);

    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    rx_state_e         state, nxt;
    logic [DW-1:0]     remain;
    logic [PW-1:0]     sel;
    logic              tag_hit;
    logic [7:0]        port_num;
    logic              port_ok;
    logic              sel_req;
    logic              take;

    assign tag_hit  = (rx_data[DW-1 -: 16] == PROTO_TAG);
    assign port_num = rx_data[7:0];
    assign port_ok  = (32'(port_num) < 32'(NPORTS));
    assign sel_req  = rd_req[sel];
    assign take     = (state == RX_HOLD) && rx_vld && sel_req;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_LEN:  if (rx_vld) nxt = RX_SCAN;
            RX_SCAN: if (rx_vld && tag_hit) begin
                         if (!port_ok)         nxt = RX_DROP;
                         else if (remain == 0) nxt = RX_LEN;
                         else                  nxt = RX_HOLD;
                     end
            RX_HOLD: if (take && remain == DW'(1)) nxt = RX_LEN;
            RX_DROP: nxt = RX_LEN;
            default: nxt = RX_LEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_LEN;
            remain <= '0;
            sel    <= '0;
        end else begin
            state <= nxt;
            if (state == RX_LEN && rx_vld)
                remain <= rx_data;
            if (state == RX_SCAN && rx_vld && tag_hit && port_ok)
                sel <= port_num[PW-1:0];
            if (take)
                remain <= remain - DW'(1);
        end
    end

    always_comb begin
        rx_rdy     = 1'b0;
        rx_drop    = 1'b0;
        rd_ack     = '0;
        port_ready = '0;
        unique case (state)
            RX_LEN, RX_SCAN: rx_rdy = 1'b1;
            RX_HOLD: begin
                rx_rdy          = sel_req;
                port_ready[sel] = 1'b1;
                if (take) rd_ack[sel] = 1'b1;
            end
            RX_DROP: rx_drop = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fd_rr_pick.sv
module fd_rr_pick #(
    parameter int NPORTS = 4,
    parameter int PW     = 2
) (
    input  logic [NPORTS-1:0] req,
    input  logic [PW-1:0]     last,
    output logic [PW-1:0]     grant,
    output logic              any
);

    always_comb begin
        grant = '0;
        any   = |req;
        for (int k = NPORTS; k >= 1; k--) begin
            int idx;
            idx = (int'(last) + k) % NPORTS;
            if (req[idx]) grant = PW'(idx);
        end
    end

endmodule

// File: rtl/fd_tx_mux.sv
module fd_tx_mux
    import fd_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    tx_vld,
    input  logic [2*NPORTS-1:0]  tx_tag,
    input  logic [DW*NPORTS-1:0] tx_data,
    output logic [NPORTS-1:0]    tx_ack,
    output logic                 out_vld,
    output logic [DW-1:0]        out_data,
    input  logic                 out_rdy
);

    localparam int PW = (NPORTS > 1) ? $clog2(NPORTS) : 1;

    tx_state_e         state, nxt;
    logic [PW-1:0]     gnt, last_q, pick;
    logic [DW-1:0]     seq_q;
    logic [NPORTS-1:0] start_req;
    logic              any_start;
    logic              cur_vld;
    logic [1:0]        cur_tag;
    logic [DW-1:0]     cur_data;
    logic [DW-1:0]     hdr_word;
    logic              beat;

    for (genvar i = 0; i < NPORTS; i++) begin : g_start
        assign start_req[i] = tx_vld[i] && (tx_tag[2*i +: 2] == TAG_START);
    end

    fd_rr_pick #(.NPORTS(NPORTS), .PW(PW)) u_pick (
        .req   (start_req),
        .last  (last_q),
        .grant (pick),
        .any   (any_start)
    );

    assign cur_vld  = tx_vld[gnt];
    assign cur_tag  = tx_tag[2*int'(gnt) +: 2];
    assign cur_data = tx_data[DW*int'(gnt) +: DW];
    assign hdr_word = DW'({PROTO_TAG, HDR_FLAGS, 8'(gnt)});
    assign beat     = cur_vld && out_rdy;

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (any_start) nxt = TX_HEAD;
            TX_HEAD: if (out_rdy)   nxt = TX_SEQ;
            TX_SEQ:  if (out_rdy)   nxt = TX_LEN;
            TX_LEN:  if (beat)      nxt = TX_BODY;
            TX_BODY: if (beat && cur_tag == TAG_END) nxt = TX_IDLE;
            default: nxt = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            gnt    <= '0;
            last_q <= PW'(NPORTS - 1);
            seq_q  <= '0;
        end else begin
            state <= nxt;
            if (state == TX_IDLE && any_start)
                gnt <= pick;
            if (state == TX_BODY && beat && cur_tag == TAG_END) begin
                seq_q  <= seq_q + DW'(1);
                last_q <= gnt;
            end
        end
    end

    always_comb begin
        out_vld  = 1'b0;
        out_data = '0;
        tx_ack   = '0;
        unique case (state)
            TX_IDLE: ;
            TX_HEAD: begin
                out_vld  = 1'b1;
                out_data = hdr_word;
            end
            TX_SEQ: begin
                out_vld  = 1'b1;
                out_data = seq_q;
            end
            TX_LEN, TX_BODY: begin
                out_vld  = cur_vld;
                out_data = cur_data;
                if (beat) tx_ack[gnt] = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/frame_dispatch.sv
module frame_dispatch #(
    parameter int NPORTS = 4,
    parameter int DW     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_vld,
    input  logic [DW-1:0]        rx_data,
    output logic                 rx_rdy,
    output logic                 rx_drop,
    input  logic [NPORTS-1:0]    rd_req,
    output logic [NPORTS-1:0]    rd_ack,
    output logic [DW-1:0]        rd_data,
    output logic [NPORTS-1:0]    port_ready,
    input  logic [NPORTS-1:0]    tx_vld,
    input  logic [2*NPORTS-1:0]  tx_tag,
    input  logic [DW*NPORTS-1:0] tx_data,
    output logic [NPORTS-1:0]    tx_ack,
    output logic                 out_vld,
    output logic [DW-1:0]        out_data,
    input  logic                 out_rdy
);

    assign rd_data = rx_data;

    fd_rx_demux #(.NPORTS(NPORTS), .DW(DW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_vld     (rx_vld),
        .rx_data    (rx_data),
        .rx_rdy     (rx_rdy),
        .rx_drop    (rx_drop),
        .rd_req     (rd_req),
        .rd_ack     (rd_ack),
        .port_ready (port_ready)
    );

    fd_tx_mux #(.NPORTS(NPORTS), .DW(DW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_vld   (tx_vld),
        .tx_tag   (tx_tag),
        .tx_data  (tx_data),
        .tx_ack   (tx_ack),
        .out_vld  (out_vld),
        .out_data (out_data),
        .out_rdy  (out_rdy)
    );

endmodule

// File: rtl/fd_checker.sv
module fd_checker #(
    parameter int NPORTS = 4,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_rdy,
    input logic              rx_drop,
    input logic [NPORTS-1:0] rd_ack,
    input logic [NPORTS-1:0] port_ready,
    input logic [NPORTS-1:0] tx_ack,
    input logic              out_vld,
    input logic [DW-1:0]     out_data,
    input logic              out_rdy
);

    // R3
    flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_ready));

    // R7
    ack_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack & ~port_ready) == '0);

    // R4
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |-> (port_ready == '0) && !rx_rdy);

    // R4
    drop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> !rx_drop);

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld && !out_rdy |=> out_vld && $stable(out_data));

    // R10
    tx_ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_ack));

    // R10
    tx_ack_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ack != '0) |-> out_vld && out_rdy);

endmodule

bind frame_dispatch fd_checker #(.NPORTS(NPORTS), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_rdy     (rx_rdy),
    .rx_drop    (rx_drop),
    .rd_ack     (rd_ack),
    .port_ready (port_ready),
    .tx_ack     (tx_ack),
    .out_vld    (out_vld),
    .out_data   (out_data),
    .out_rdy    (out_rdy)
);

// File: tb/tb_frame_dispatch.sv
module tb_frame_dispatch;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic              rx_vld = 1'b0;
    logic [DW-1:0]     rx_data = '0;
    logic              rx_rdy, rx_drop;
    logic [NP-1:0]     rd_req = '0;
    logic [NP-1:0]     rd_ack, port_ready;
    logic [DW-1:0]     rd_data;
    logic [NP-1:0]     tx_vld;
    logic [2*NP-1:0]   tx_tag;
    logic [DW*NP-1:0]  tx_data;
    logic [NP-1:0]     tx_ack;
    logic              out_vld;
    logic [DW-1:0]     out_data;
    logic              out_rdy = 1'b0;

    frame_dispatch #(.NPORTS(NP), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .rx_vld(rx_vld), .rx_data(rx_data), .rx_rdy(rx_rdy), .rx_drop(rx_drop),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .port_ready(port_ready),
        .tx_vld(tx_vld), .tx_tag(tx_tag), .tx_data(tx_data), .tx_ack(tx_ack),
        .out_vld(out_vld), .out_data(out_data), .out_rdy(out_rdy)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // transmit clients
    logic [31:0] cw [NP][16];
    logic [1:0]  ct [NP][16];
    int ccnt [NP];
    int cptr [NP];

    always @(posedge clk) begin
        for (int i = 0; i < NP; i++) begin
            if (!rst_n) cptr[i] <= 0;
            else if (tx_ack[i]) cptr[i] <= cptr[i] + 1;
        end
    end

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            tx_vld[i]          = cptr[i] < ccnt[i];
            tx_data[DW*i +: DW] = cw[i][cptr[i] % 16];
            tx_tag[2*i +: 2]   = ct[i][cptr[i] % 16];
        end
    end

    // downstream: stall one cycle in three
    int ocyc = 0;
    always @(negedge clk) begin
        ocyc    <= ocyc + 1;
        out_rdy <= (ocyc % 3) != 2;
    end

    logic [31:0] got [128];
    int gcnt = 0;
    always @(posedge clk) begin
        if (rst_n && out_vld && out_rdy) begin
            got[gcnt % 128] <= out_data;
            gcnt <= gcnt + 1;
        end
    end

    logic [31:0] exp_w [128];
    int ecnt = 0;
    int seq_exp = 0;

    function automatic logic [31:0] pay(input int i, input int f, input int j);
        return 32'hA000_0000 | (i << 16) | (f << 8) | j;
    endfunction

    task automatic add_frame(input int i, input int f, input int len);
        cw[i][ccnt[i] % 16] = len;
        ct[i][ccnt[i] % 16] = 2'b01;
        for (int j = 0; j < len; j++) begin
            cw[i][(ccnt[i] + 1 + j) % 16] = pay(i, f, j);
            ct[i][(ccnt[i] + 1 + j) % 16] = (j == len - 1) ? 2'b10 : 2'b00;
        end
        ccnt[i] = ccnt[i] + 1 + len;
    endtask

    task automatic exp_frame(input int i, input int f, input int len);
        exp_w[ecnt] = {16'h45C0, 8'h32, 8'(i)}; ecnt++;
        exp_w[ecnt] = seq_exp;                  ecnt++;
        seq_exp++;
        exp_w[ecnt] = len;                      ecnt++;
        for (int j = 0; j < len; j++) begin
            exp_w[ecnt] = pay(i, f, j); ecnt++;
        end
    endtask

    function automatic bit clients_done();
        for (int i = 0; i < NP; i++)
            if (cptr[i] != ccnt[i]) return 1'b0;
        return 1'b1;
    endfunction

    // one receive word transfer, optionally as a client read on port rp
    task automatic xfer(input logic [31:0] w, input int rp);
        @(negedge clk);
        rx_data = w;
        rx_vld  = 1'b1;
        rd_req  = (rp >= 0) ? ((NP'(1) << rp) | (NP'(1) << ((rp + 1) % NP))) : '0;
        #1;
        while (!rx_rdy) begin
            @(negedge clk);
            #1;
        end
        if (rp >= 0) begin
            check("R5 R7 acknowledge only on flagged port", 32'(rd_ack), 32'(NP'(1) << rp));
            check("R5 read data", rd_data, w);
        end
        @(posedge clk);
        #1;
        rx_vld = 1'b0;
        rd_req = '0;
    endtask

    task automatic rx_frame(input int p, input int len, input int junk);
        xfer(len, -1);
        for (int j = 0; j < junk; j++) xfer(32'h1234_0000 | j, -1);
        xfer({16'h45C0, 8'h32, 8'(p)}, -1);
        @(negedge clk);
        #1;
        if (p >= NP) begin
            check("R4 discard strobe", 32'(rx_drop), 1);
            check("R4 no flag on bad port", 32'(port_ready), 0);
        end else if (len == 0) begin
            check("R8 zero length raises no flag", 32'(port_ready), 0);
        end else begin
            check("R2 R3 flag of addressed port", 32'(port_ready), 32'(NP'(1) << p));
            for (int j = 0; j < len; j++) xfer(32'hC000_0000 | (p << 8) | j, p);
            @(negedge clk);
            #1;
            check("R6 flag cleared after last read", 32'(port_ready), 0);
            check("R6 ready for next length", 32'(rx_rdy), 1);
        end
    endtask

    task automatic rx_thread();
        for (int p = 0; p < NP + 2; p++)
            for (int len = 1; len <= 3; len++)
                rx_frame(p, len, len - 1);
        rx_frame(1, 0, 1);
        rx_frame(2, 2, 0);
    endtask

    task automatic wait_clients();
        while (!clients_done()) @(negedge clk);
    endtask

    task automatic tx_thread();
        wait_clients();
        @(negedge clk);
        add_frame(0, 1, 2);
        add_frame(2, 1, 3);
        exp_frame(0, 1, 2);
        exp_frame(2, 1, 3);
        wait_clients();
        @(negedge clk);
        add_frame(1, 1, 1);
        add_frame(3, 1, 2);
        exp_frame(3, 1, 2);
        exp_frame(1, 1, 1);
        wait_clients();
        while (gcnt < ecnt) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10 R11 output word count", gcnt, ecnt);
        for (int k = 0; k < ecnt; k++)
            check("R9 R10 R11 output word", got[k], exp_w[k]);
    endtask

    task automatic run_all();
        for (int i = 0; i < 4; i++) add_frame(i, 0, i + 1);
        for (int i = 0; i < 4; i++) exp_frame(i, 0, i + 1);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 no flags after reset", 32'(port_ready), 0);
        check("R1 output idle after reset", 32'(out_vld), 0);
        rd_req = '1;
        #1;
        check("R1 R7 no acknowledge without flag", 32'(rd_ack), 0);
        rd_req = '0;
        fork
            rx_thread();
            tx_thread();
        join
    endtask

    initial begin
        for (int i = 0; i < NP; i++) ccnt[i] = 0;
        fork
            run_all();
            begin
                repeat (50000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule